// File: doc/BRIEF.md
# Fully Associative First-Level Address Translator

This block sits between a load/store unit and the data cache and turns a 32-bit virtual address into a 32-bit physical address. Pages are 4 KB. The upper 20 bits of the address are the virtual page number, and the low 12 bits pass through unchanged. The block keeps ten translations. Every lookup compares the page number against all ten entries at the same time. On a hit, the physical address is returned combinationally in the same cycle as the request.

When no entry matches, the block holds off further requests and asks a larger second-level translation buffer for the missing page. It keeps that request raised until the answer arrives. In the answer cycle it returns the translated address to the waiting requester and stores the new translation. The instruction side and the data side each use their own copy of this block. A single invalidate-all input empties the buffer in one cycle.

Top module: `micro_tlb`

## Requirements
- R1: After synchronous reset, all entries are invalid, `req_ready` is 1, `l2_req_valid` is 0 and `rsp_valid` is 0 when no request is presented.
- R2: A request accepted while `req_valid` and `req_ready` are both high, whose page number `req_vaddr[31:12]` matches a valid entry, raises `rsp_valid` in the same cycle. In that case `rsp_paddr` = {stored page, `req_vaddr[11:0]`}.
- R3: An accepted request that matches no entry gives `rsp_valid` = 0 in that cycle. From the next cycle, `l2_req_valid` is 1 and `l2_req_vpn` holds the missed page number. `req_ready` stays 0, and these outputs stay fixed until `l2_rsp_valid` arrives.
- R4: In the cycle `l2_rsp_valid` is high while a request is outstanding, `rsp_valid` is 1 and `rsp_paddr` = {`l2_rsp_ppn`, offset of the missed request}. In the next cycle `l2_req_valid` is 0 and `req_ready` is 1.
- R5: After a refill, a lookup of the refilled page hits and returns the page that was supplied. No page is ever held in two entries at once.
- R6: A refill is written into the lowest-indexed invalid entry when one exists.
- R7: When all entries are valid, a refill replaces the entry named by a rotating pointer. The pointer is 0 after reset and advances by one on each refill into a full buffer. It wraps from entry 9 to entry 0, and an invalidate-all leaves it unchanged.
- R8: `inv_all` clears every entry in one cycle. While it is high, `req_ready` is 0 and no response is given. This also holds when `inv_all` arrives while a miss is outstanding, and the refill that follows is then written into entry 0.
- R9: While a miss is outstanding, changes on `req_valid` and `req_vaddr` have no effect on `l2_req_vpn` or on the address returned by the refill.
- R10: `l2_rsp_valid` while no miss is outstanding is ignored. It produces no response and installs no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | Translated address valid |
| rsp_paddr | output | 32 | Physical address |
| l2_req_valid | output | 1 | Request to second-level buffer outstanding |
| l2_req_vpn | output | 20 | Page number requested from second level |
| l2_rsp_valid | input | 1 | Second-level answer present |
| l2_rsp_ppn | input | 20 | Physical page returned by second level |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The bench fills the ten entries from empty and then overflows them repeatedly. A design that picked the wrong victim, let the rotating pointer skip a step, or failed to wrap after entry 9 would turn expected hits into misses on later lookups. It changes the request address while a miss is outstanding and uses refill latencies from zero to three cycles. A design that sampled the live address would return the wrong offset or request the wrong page. It also pulses invalidate-all both when idle and during a miss, and sends unsolicited second-level answers. A wrong design would keep stale hits, accept a lookup during the clear, or install a phantom entry.

// File: rtl/mtlb_pkg.sv
package mtlb_pkg;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [OFF_W-1:0] off_t;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
        ppn_t ppn;
    } tlb_ent_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } mstate_e;

    function automatic int wrap_next(input int cur, input int n);
        return (cur >= n - 1) ? 0 : cur + 1;
    endfunction
endpackage

// File: rtl/mtlb_store.sv
module mtlb_store
    import mtlb_pkg::*;
#(
    parameter int N_ENT = 10,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  vpn_t             wr_vpn,
    input  ppn_t             wr_ppn,
    input  vpn_t             lk_vpn,
    output logic [N_ENT-1:0] match_vec,
    output logic [N_ENT-1:0] valid_vec,
    output ppn_t             match_ppn
);
    logic [N_ENT-1:0][PPN_W-1:0] masked_ppn;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        tlb_ent_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else begin
                if (clr_all) ent_q.valid <= 1'b0;
                if (wr_en && wr_idx == IDX_W'(g)) begin
                    ent_q <= '{valid: 1'b1, vpn: wr_vpn, ppn: wr_ppn};
                end
            end
        end

        assign valid_vec[g]  = ent_q.valid;
        assign match_vec[g]  = ent_q.valid && (ent_q.vpn == lk_vpn);
        assign masked_ppn[g] = match_vec[g] ? ent_q.ppn : '0;
    end

    // At most one entry matches, so an OR tree acts as the output mux.
    always_comb begin
        match_ppn = '0;
        for (int i = 0; i < N_ENT; i++) begin
            match_ppn = match_ppn | masked_ppn[i];
        end
    end
endmodule

// File: rtl/mtlb_victim.sv
module mtlb_victim
    import mtlb_pkg::*;
#(
    parameter int N_ENT = 10,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_ENT-1:0] valid_vec,
    input  logic             fill,
    output logic [IDX_W-1:0] victim_idx
);
    logic [IDX_W-1:0] rr_q;
    logic             full;

    assign full = &valid_vec;

    // Scan from the top so the lowest free slot is the last one written.
    always_comb begin
        victim_idx = rr_q;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (fill && full) begin
            rr_q <= IDX_W'(wrap_next(int'(rr_q), N_ENT));
        end
    end
endmodule

// File: rtl/mtlb_ctrl.sv
module mtlb_ctrl
    import mtlb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lookup_fire,
    input  logic lookup_hit,
    input  vpn_t lk_vpn,
    input  off_t lk_off,
    input  logic l2_rsp_valid,
    output logic busy,
    output logic refill,
    output vpn_t miss_vpn,
    output off_t miss_off
);
    mstate_e state_q;

    assign busy   = (state_q == ST_WAIT);
    assign refill = busy && l2_rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            miss_vpn <= '0;
            miss_off <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (lookup_fire && !lookup_hit) begin
                    state_q  <= ST_WAIT;
                    miss_vpn <= lk_vpn;
                    miss_off <= lk_off;
                end
                ST_WAIT: if (l2_rsp_valid) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/micro_tlb.sv
module micro_tlb
    import mtlb_pkg::*;
#(
    parameter int N_ENT = 10,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             l2_req_valid,
    output logic [VPN_W-1:0] l2_req_vpn,
    input  logic             l2_rsp_valid,
    input  logic [PPN_W-1:0] l2_rsp_ppn,
    input  logic             inv_all
);
    logic [N_ENT-1:0] hit_vec;
    logic [N_ENT-1:0] valid_vec;
    logic [IDX_W-1:0] victim_idx;
    ppn_t             hit_ppn;
    vpn_t             lk_vpn;
    off_t             lk_off;
    vpn_t             miss_vpn;
    off_t             miss_off;
    logic             hit;
    logic             busy;
    logic             refill;
    logic             lookup_fire;

    assign lk_vpn      = req_vaddr[VA_W-1:OFF_W];
    assign lk_off      = req_vaddr[OFF_W-1:0];
    assign hit         = |hit_vec;
    assign req_ready   = !busy && !inv_all;
    assign lookup_fire = req_valid && req_ready;

    mtlb_store #(.N_ENT(N_ENT)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr_all   (inv_all),
        .wr_en     (refill),
        .wr_idx    (victim_idx),
        .wr_vpn    (miss_vpn),
        .wr_ppn    (l2_rsp_ppn),
        .lk_vpn    (lk_vpn),
        .match_vec (hit_vec),
        .valid_vec (valid_vec),
        .match_ppn (hit_ppn)
    );

    mtlb_victim #(.N_ENT(N_ENT)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .valid_vec  (valid_vec),
        .fill       (refill),
        .victim_idx (victim_idx)
    );

    mtlb_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .lookup_fire  (lookup_fire),
        .lookup_hit   (hit),
        .lk_vpn       (lk_vpn),
        .lk_off       (lk_off),
        .l2_rsp_valid (l2_rsp_valid),
        .busy         (busy),
        .refill       (refill),
        .miss_vpn     (miss_vpn),
        .miss_off     (miss_off)
    );

    assign l2_req_valid = busy;
    assign l2_req_vpn   = miss_vpn;
    assign rsp_valid    = (lookup_fire && hit) || refill;
    assign rsp_paddr    = refill ? {l2_rsp_ppn, miss_off} : {hit_ppn, lk_off};
endmodule

// File: rtl/micro_tlb_chk.sv
module micro_tlb_chk
    import mtlb_pkg::*;
#(
    parameter int N_ENT = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             l2_req_valid,
    input logic [VPN_W-1:0] l2_req_vpn,
    input logic             l2_rsp_valid,
    input logic [PPN_W-1:0] l2_rsp_ppn,
    input logic             inv_all,
    input logic [N_ENT-1:0] hit_vec
);
    p_hit_offset_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && rsp_valid) |-> rsp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]);

    p_miss_request_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !rsp_valid) |=> (l2_req_valid && !req_ready));

    p_request_held_r3: assert property (@(posedge clk) disable iff (rst)
        (l2_req_valid && !l2_rsp_valid) |=> (l2_req_valid && $stable(l2_req_vpn)));

    p_refill_answer_r4: assert property (@(posedge clk) disable iff (rst)
        (l2_req_valid && l2_rsp_valid) |-> (rsp_valid && rsp_paddr[PA_W-1:OFF_W] == l2_rsp_ppn));

    p_refill_release_r4: assert property (@(posedge clk) disable iff (rst)
        (l2_req_valid && l2_rsp_valid) |=> !l2_req_valid);

    p_single_match_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    p_clear_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        inv_all |-> !req_ready);

    p_stray_answer_r10: assert property (@(posedge clk) disable iff (rst)
        (!l2_req_valid && l2_rsp_valid && !req_valid) |-> !rsp_valid);
endmodule

bind micro_tlb micro_tlb_chk #(.N_ENT(N_ENT)) u_chk (.*);

// File: tb/micro_tlb_bench.sv
module micro_tlb_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        l2_req_valid;
    logic [19:0] l2_req_vpn;
    logic        l2_rsp_valid = 1'b0;
    logic [19:0] l2_rsp_ppn = '0;
    logic        inv_all = 1'b0;

    int n_vec = 0;
    int n_fail = 0;

    bit          m_valid [N];
    logic [19:0] m_vpn   [N];
    logic [19:0] m_ppn   [N];
    int          m_rr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    micro_tlb u_micro_tlb (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .rsp_paddr    (rsp_paddr),
        .l2_req_valid (l2_req_valid),
        .l2_req_vpn   (l2_req_vpn),
        .l2_rsp_valid (l2_rsp_valid),
        .l2_rsp_ppn   (l2_rsp_ppn),
        .inv_all      (inv_all)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] l2_map(input logic [19:0] v);
        return {v[7:0], v[19:8]} ^ 20'h3C5A1;
    endfunction

    function automatic int m_find(input logic [19:0] v);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    task automatic m_install(input logic [19:0] v, input logic [19:0] p);
        int idx = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) idx = i;
        if (idx < 0) begin
            idx = m_rr;
            m_rr = (m_rr == N - 1) ? 0 : m_rr + 1;
        end
        m_valid[idx] = 1'b1;
        m_vpn[idx]   = v;
        m_ppn[idx]   = p;
    endtask

    task automatic m_clear();
        for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    endtask

    // One translation; tag names the requirement behind the hit/miss outcome.
    task automatic lookup(input logic [31:0] va, input int lat, input bit mid_flush, input string tag);
        logic [19:0] vpn = va[31:12];
        int hidx = m_find(vpn);
        logic [19:0] p;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        #2;
        chk({tag, " hit/miss"}, {31'd0, rsp_valid}, {31'd0, hidx >= 0});
        if (hidx >= 0) begin
            chk("R2 hit address", rsp_paddr, {m_ppn[hidx], va[11:0]});
            @(posedge clk);
            #1 req_valid = 1'b0;
        end else begin
            @(negedge clk);
            #2;
            chk("R3 request raised", {31'd0, l2_req_valid}, 32'd1);
            chk("R3 requested page", {12'd0, l2_req_vpn}, {12'd0, vpn});
            chk("R3 ready low", {31'd0, req_ready}, 32'd0);
            req_vaddr = $urandom;
            req_valid = $urandom % 2;
            if (mid_flush) begin
                inv_all = 1'b1;
                #1 chk("R8 ready low on clear", {31'd0, req_ready}, 32'd0);
                @(posedge clk);
                #1 inv_all = 1'b0;
                m_clear();
                @(negedge clk);
                #2;
            end
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                #2;
                chk("R9 page held in stall", {12'd0, l2_req_vpn}, {12'd0, vpn});
                req_vaddr = $urandom;
            end
            p = l2_map(vpn);
            l2_rsp_valid = 1'b1;
            l2_rsp_ppn   = p;
            #1;
            chk("R4 refill answer valid", {31'd0, rsp_valid}, 32'd1);
            chk("R4 refill address R9", rsp_paddr, {p, va[11:0]});
            @(posedge clk);
            #1;
            l2_rsp_valid = 1'b0;
            req_valid    = 1'b0;
            m_install(vpn, p);
            @(negedge clk);
            #2;
            chk("R4 request dropped", {31'd0, l2_req_valid}, 32'd0);
            chk("R4 ready back", {31'd0, req_ready}, 32'd1);
        end
    endtask

    task automatic flush_idle();
        @(negedge clk);
        inv_all   = 1'b1;
        req_valid = 1'b1;
        req_vaddr = {m_vpn[0], 12'h123};
        #2;
        chk("R8 ready low on clear", {31'd0, req_ready}, 32'd0);
        chk("R8 no answer on clear", {31'd0, rsp_valid}, 32'd0);
        @(posedge clk);
        #1;
        inv_all   = 1'b0;
        req_valid = 1'b0;
        m_clear();
    endtask

    task automatic stray_answer();
        @(negedge clk);
        l2_rsp_valid = 1'b1;
        l2_rsp_ppn   = $urandom;
        #2;
        chk("R10 stray answer ignored", {31'd0, rsp_valid}, 32'd0);
        @(posedge clk);
        #1 l2_rsp_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed = $urandom(32'd4711);
        m_clear();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        #2;
        chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 no request after reset", {31'd0, l2_req_valid}, 32'd0);
        chk("R1 no answer after reset", {31'd0, rsp_valid}, 32'd0);
        lookup(32'h0010_0ABC, 0, 1'b0, "R1");

        // Fill the free slots in order, then confirm each one hits.
        for (int i = 1; i < N; i++) lookup({20'h00100 + 20'(i), 12'h040}, i % 4, 1'b0, "R6");
        for (int i = 0; i < N; i++) lookup({20'h00100 + 20'(i), 12'hFFF}, 0, 1'b0, "R5");
        // Full: rotating pointer picks slots 0, 1, 2 in turn.
        lookup(32'h0020_0000, 1, 1'b0, "R7");
        lookup(32'h0010_0001, 0, 1'b0, "R7");
        lookup(32'h0010_2002, 0, 1'b0, "R7");
        lookup(32'h0010_1003, 2, 1'b0, "R7");
        lookup(32'h0010_3004, 0, 1'b0, "R7");
        stray_answer();
        lookup(32'h0077_7000, 0, 1'b0, "R10");
        flush_idle();
        lookup(32'h0010_3555, 0, 1'b0, "R8");
        lookup(32'h0010_4666, 1, 1'b1, "R8");
        lookup(32'h0010_3777, 0, 1'b0, "R8");
        lookup(32'h0010_4888, 0, 1'b0, "R6");

        for (int it = 0; it < 400; it++) begin
            int sel = $urandom % 60;
            if (sel == 0) flush_idle();
            else if (sel == 1) stray_answer();
            else lookup({20'h20000 + 20'(($urandom % 14) * 3), 12'($urandom)},
                        $urandom % 4, ($urandom % 25) == 0, "R7");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule